// File: doc/BRIEF.md
# Dual-Path SPI Clock Rate Generator

This block turns a fast source clock into the toggle strobe that paces an SPI shift engine. Each strobe marks one edge of the serial clock, and strobes are evenly spaced, so the serial clock it implies has a 50% duty cycle. The spacing comes from one of two divider paths, chosen by a single select input.

The first path divides in powers of two. A 3-bit code N gives a total divide of 2^(N+2), so the codes 0, 1, 2 and 3 give 4, 8, 16 and 32. The second path divides linearly. An 8-bit code N gives a total divide of 2×(N+1). The block also reports the divide ratio that is in force at the moment.

The shift engine holds the generator idle while the controller is disabled. At the start of each burst it pulses a restart input. A new code or a new path choice is taken up only where one serial-clock period ends, so a change made during a period never shortens or stretches a half period.

Top module: `spiclk_gen`

## Requirements
- R1: With `path_sel_i` = 0 (power-of-two path), the ratio is 2^(N+2) for N = `pow2_code_i`, and `lin_code_i` has no effect. For example, N = 0 gives 4, N = 3 gives 32 and N = 7 gives 512.
- R2: With `path_sel_i` = 1 (linear path), the ratio is 2×(N+1) for N = `lin_code_i`, and `pow2_code_i` has no effect. For example, N = 4 gives 10 and N = 255 gives 512.
- R3: `ratio_o` reports the ratio that is in force. When the selected path changes, the other path's code takes over.
- R4: While enabled, consecutive `tick_o` pulses are exactly ratio/2 source cycles apart (equal half periods).
- R5: `start_i` sampled high together with `en_i` at clock edge k clears the count. The first `tick_o` is then high in the cycle that follows edge k + ratio/2.
- R6: While `en_i` is low, `tick_o` stays low. From the edge at which `en_i` is sampled low, `ratio_o` follows the live inputs one cycle later.
- R7: While running, a change to the codes or to the path takes effect only at a period boundary, which is the second strobe of a period. Up to that strobe, `ratio_o` and the strobe spacing keep their old values.
- R8: After synchronous reset, `tick_o` is 0 and `ratio_o` is 4.
- R9: The smallest linear setting (N = 0, ratio 2) gives a strobe on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Controller enabled; low holds the generator idle |
| start_i | input | 1 | Burst start: restarts the count at zero |
| path_sel_i | input | 1 | 0 selects the power-of-two path, 1 selects the linear path |
| pow2_code_i | input | 3 | Exponent code for the power-of-two path |
| lin_code_i | input | 8 | Code for the linear path |
| tick_o | output | 1 | One-cycle serial-clock toggle strobe |
| ratio_o | output | 10 | Divide ratio in force (source cycles per serial-clock period) |

## Verification
The hardest case to reach is a settings change that lands mid-period. It has to arrive after the first strobe of a period and before the second. The only evidence that it was deferred is that the next half period still uses the old spacing, followed by an abrupt switch.

The bench restarts a run with a known slow linear setting and waits for the first strobe. In that exact cycle it switches to the fastest setting. It then measures the gap to the next strobe and checks the reported ratio before and after the boundary. Large ratios at both ends of each path are timed in the same way, from restart to strobe.

// File: rtl/spiclk_pkg.sv
// Shared types for the SPI clock rate generator.
package spiclk_pkg;
    // Which divider path sets the strobe spacing.
    typedef enum logic {
        PATH_POW2   = 1'b0,
        PATH_LINEAR = 1'b1
    } path_e;
endpackage

// File: rtl/spiclk_ratio_sel.sv
// Ratio selector: derives the half-period length and the full divide ratio
// from the two divide codes and the path select.
// Assumes: HALF_W is wide enough to hold 2^(2^POW2_W - 1 + 1) and 2^LIN_W.
// Purely combinational.
module spiclk_ratio_sel
    import spiclk_pkg::*;
#(
    parameter int POW2_W  = 3,
    parameter int LIN_W   = 8,
    parameter int HALF_W  = 9,
    parameter int RATIO_W = 10
) (
    input  logic [POW2_W-1:0]  pow2_code_i,
    input  logic [LIN_W-1:0]   lin_code_i,
    input  logic               path_sel_i,
    output logic [HALF_W-1:0]  half_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int SH_W = POW2_W + 1;

    logic [SH_W-1:0]   pow2_shift;
    logic [HALF_W-1:0] pow2_half;
    logic [HALF_W-1:0] lin_half;
    path_e             path;

    // Half period per path: 2^(N+1) or N+1 source cycles.
    always_comb begin
        pow2_shift = SH_W'(pow2_code_i) + SH_W'(1);
        pow2_half  = HALF_W'(1) << pow2_shift;
        lin_half   = HALF_W'(lin_code_i) + HALF_W'(1);
        path       = path_e'(path_sel_i);
        half_o     = (path == PATH_LINEAR) ? lin_half : pow2_half;
        ratio_o    = RATIO_W'({half_o, 1'b0});
    end
endmodule

// File: rtl/spiclk_half_counter.sv
// Half-period counter: counts source cycles and raises a one-cycle strobe
// each time a half period of the serial clock ends. It tracks which half
// of the period is running, so the caller can spot the end of a period.
// Assumes: half_i >= 1, and half_i changes only while the count is zero.
module spiclk_half_counter #(
    parameter int HALF_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              wrap_o,
    output logic              phase_o,
    output logic              tick_o
);
    logic [HALF_W-1:0] cnt_q;
    logic              phase_q;
    logic              tick_q;

    // Last cycle of a half period while running freely.
    assign wrap_o  = en_i && !start_i && (cnt_q == half_i - HALF_W'(1));
    assign phase_o = phase_q;
    assign tick_o  = tick_q;

    // Count, flip the half-period phase and emit the strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || start_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            tick_q  <= 1'b0;
        end else if (wrap_o) begin
            cnt_q   <= '0;
            phase_q <= !phase_q;
            tick_q  <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + HALF_W'(1);
            tick_q  <= 1'b0;
        end
    end

    // R4: the count never reaches the half-period length.
    p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < half_i);

    // R6: a disabled generator emits no strobe.
    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !tick_o);

    // R5: a burst start clears the count and suppresses the strobe.
    p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && start_i) |=> (cnt_q == '0 && !tick_o && !phase_q));
endmodule

// File: rtl/spiclk_gen.sv
// Dual-path SPI clock rate generator (top). Selects a power-of-two or a
// linear divide and paces the serial clock through a half-period counter.
// The selected ratio is captured while idle, at a burst start, and at each
// serial-clock period boundary, so the setting never changes inside a period.
// Assumes: synchronous active-low reset; one clock domain.
module spiclk_gen #(
    parameter int POW2_W = 3,
    parameter int LIN_W  = 8,
    localparam int POW2_BITS = (1 << POW2_W) + 2,
    localparam int LIN_BITS  = LIN_W + 2,
    localparam int RATIO_W   = (POW2_BITS > LIN_BITS) ? POW2_BITS : LIN_BITS,
    localparam int HALF_W    = RATIO_W - 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               start_i,
    input  logic               path_sel_i,
    input  logic [POW2_W-1:0]  pow2_code_i,
    input  logic [LIN_W-1:0]   lin_code_i,
    output logic               tick_o,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [HALF_W-1:0]  live_half;
    logic [RATIO_W-1:0] live_ratio;
    logic [HALF_W-1:0]  half_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               wrap;
    logic               phase;
    logic               period_end;
    logic               load;

    spiclk_ratio_sel #(
        .POW2_W (POW2_W),
        .LIN_W  (LIN_W),
        .HALF_W (HALF_W),
        .RATIO_W(RATIO_W)
    ) u_sel (
        .pow2_code_i(pow2_code_i),
        .lin_code_i (lin_code_i),
        .path_sel_i (path_sel_i),
        .half_o     (live_half),
        .ratio_o    (live_ratio)
    );

    spiclk_half_counter #(
        .HALF_W(HALF_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .start_i(start_i),
        .half_i (half_q),
        .wrap_o (wrap),
        .phase_o(phase),
        .tick_o (tick_o)
    );

    // A period ends on the wrap that closes its second half.
    assign period_end = wrap && phase;
    assign load       = !en_i || start_i || period_end;
    assign ratio_o    = ratio_q;

    // Capture the selected ratio only at the safe points.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            half_q  <= HALF_W'(2);
            ratio_q <= RATIO_W'(4);
        end else if (load) begin
            half_q  <= live_half;
            ratio_q <= live_ratio;
        end
    end

    // R7: the ratio in force holds steady inside a running period.
    p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !start_i && !period_end) |=> $stable(ratio_o));

    // R1: any ratio in force is even and at least 2.
    p_ratio_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ratio_o[0] == 1'b0) && (ratio_o >= RATIO_W'(2)));
endmodule

// File: tb/spiclk_gen_tb.sv
// Self-checking bench for the dual-path SPI clock rate generator.
module spiclk_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       start;
    logic       sel;
    logic [2:0] p2;
    logic [7:0] lin;
    logic       tick;
    logic [9:0] ratio;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spiclk_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .start_i    (start),
        .path_sel_i (sel),
        .pow2_code_i(p2),
        .lin_code_i (lin),
        .tick_o     (tick),
        .ratio_o    (ratio)
    );

    // {path select, pow2 code, linear code, expected ratio}
    localparam logic [21:0] VEC [8] = '{
        {1'b0, 3'd0, 8'd0,   10'd4},
        {1'b0, 3'd3, 8'd77,  10'd32},
        {1'b0, 3'd7, 8'd0,   10'd512},
        {1'b0, 3'd1, 8'd200, 10'd8},
        {1'b1, 3'd0, 8'd0,   10'd2},
        {1'b1, 3'd5, 8'd4,   10'd10},
        {1'b1, 3'd0, 8'd255, 10'd512},
        {1'b1, 3'd7, 8'd1,   10'd4}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count rising edges until tick is seen high at a falling edge.
    task automatic measure(output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (tick || n > 2000) return;
        end
    endtask

    // Pulse a burst start together with enable; leaves the bench at a falling edge.
    task automatic launch;
        @(negedge clk);
        en    = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input bit s, input logic [2:0] a, input logic [7:0] b);
        @(negedge clk);
        en  = 1'b0;
        sel = s;
        p2  = a;
        lin = b;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int cnt;
        rst_n = 1'b0; en = 1'b0; start = 1'b0; sel = 1'b1; p2 = 3'd4; lin = 8'd9;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(tick == 1'b0, "R8 tick in reset", tick, 0);
        chk(ratio == 10'd4, "R8 ratio in reset", ratio, 4);
        rst_n = 1'b1;

        // Vector walk: R1 R2 R3 R4 R5 R9
        for (int i = 0; i < 8; i++) begin
            int exp_r;
            int half;
            exp_r = int'(VEC[i][9:0]);
            half  = exp_r / 2;
            idle(VEC[i][21], VEC[i][20:18], VEC[i][17:10]);
            launch();
            measure(n);
            chk(n == half, "R5 first strobe delay", n, half);
            measure(n);
            chk(n == half, "R4 strobe spacing", n, half);
            if (VEC[i][21])
                chk(ratio == VEC[i][9:0], "R2 R3 linear ratio", ratio, exp_r);
            else
                chk(ratio == VEC[i][9:0], "R1 R3 pow2 ratio", ratio, exp_r);
            if (exp_r == 2) begin
                @(negedge clk);
                chk(tick == 1'b1, "R9 strobe every cycle", tick, 1);
            end
        end

        // R6: disabled, no strobes, ratio follows inputs
        idle(1'b1, 3'd0, 8'd0);
        cnt = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
        chk(cnt == 0, "R6 strobes while disabled", cnt, 0);
        lin = 8'd9;
        @(negedge clk);
        chk(ratio == 10'd20, "R6 ratio follows while idle", ratio, 20);

        // R6: dropping enable mid-run silences the strobe next cycle
        idle(1'b1, 3'd0, 8'd0);
        launch();
        measure(n);
        en = 1'b0;
        @(negedge clk);
        chk(tick == 1'b0, "R6 strobe after disable", tick, 0);

        // R7: change mid-period, deferred to the period boundary
        idle(1'b1, 3'd0, 8'd3);
        launch();
        measure(n);
        chk(n == 4, "R7 first half old spacing", n, 4);
        lin = 8'd0;
        sel = 1'b1;
        @(negedge clk);
        chk(ratio == 10'd8, "R7 ratio held mid-period", ratio, 8);
        measure(n);
        chk(n == 3, "R7 second half keeps old spacing", n + 1, 4);
        chk(ratio == 10'd2, "R7 ratio at boundary", ratio, 2);
        measure(n);
        chk(n == 1, "R7 new spacing after boundary", n, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule